// File: doc/BRIEF.md
# Control-Register Access Legality Checker

This block sits beside the register-access stage of a processor core and decides, in the same cycle, whether an access to a control register may proceed. It receives the 12-bit register address, a flag that says whether the access writes, the current register-width mode (32-bit or 64-bit), two extension-present flags and the two mode bits of the value being written. It returns a single illegal-instruction indication and, for the trap-vector register only, a strobe that allows the register file to take the write.

Pure reads and writes are judged separately. A debugger read, or any access whose write mask is zero, is presented with the write flag low and takes the read path, so it can never trip the read-only rule. The counter-configuration registers depend on the counter privilege-filter extension. Their upper halves, and the upper halves of the event selectors, exist only while the core runs in 32-bit mode. A trap-vector write that carries a reserved mode is dropped without raising an exception.

The block holds no state. Register storage and privilege decoding are handled elsewhere.

Top module: `csr_access_checker`

## Requirements
- R1: A write to any address whose bits [11:10] are 2'b11 raises `illegal_o`.
- R2: A read (`is_write_i` low) of an address whose bits [11:10] are 2'b11 does not raise `illegal_o` on account of that rule.
- R3: The cycle configuration register (0x321) and the retired-instruction configuration register (0x322), and their upper halves (0x721, 0x722), raise `illegal_o` on read or write when `ext_i[0]` (counter privilege filter) is 0.
- R4: The upper-half configuration registers (0x721, 0x722) raise `illegal_o` whenever `mode64_i` is 1, even when `ext_i[0]` is 1. They are legal in 32-bit mode when `ext_i[0]` is 1, provided R1 does not apply.
- R5: The upper-half event-selector registers (0x723 to 0x73F) raise `illegal_o` when `mode64_i` is 1, or when `ext_i[1]` (counter overflow extension) is 0. They are legal otherwise, provided R1 does not apply.
- R6: A write to the trap-vector register (0x205) with `vec_mode_i` equal to 0 (direct) or 1 (vectored) raises `tvec_we_o` and leaves `illegal_o` low.
- R7: A write to the trap-vector register with `vec_mode_i` equal to 2 or 3 (reserved) keeps `tvec_we_o` low and also keeps `illegal_o` low.
- R8: `tvec_we_o` is high only for a legal write to 0x205. It is low for reads, for every other address and whenever `illegal_o` is high.
- R9: `illegal_o` is the OR of the read-only cause and the extension/width causes. Every other listed address is legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 12 | Control-register address of the access |
| is_write_i | input | 1 | 1 = write access, 0 = pure read (including zero-mask debugger reads) |
| mode64_i | input | 1 | 1 = core in 64-bit register mode, 0 = 32-bit mode |
| ext_i | input | 2 | Extension flags: bit 0 counter privilege filter, bit 1 counter overflow |
| vec_mode_i | input | 2 | Bits [1:0] of the write data (trap-vector mode field) |
| illegal_o | output | 1 | Access must raise an illegal-instruction exception |
| tvec_we_o | output | 1 | Trap-vector register may take the write |

## Verification
Two functions can act on the same access: the read-only rule and the width/extension gate. Both apply to addresses in the upper-half event range only when that range is moved into the read-only space by parameter. With the default map they meet where the write flag and the gating flags are judged together, and also on the trap-vector strobe, which must fall whenever any rejection cause is active. The bench sweeps every listed address against every combination of write flag, width mode, the two extension flags and the four vector modes, so each collision appears. An independent arithmetic model written from the requirements judges each combination.

// File: rtl/csr_chk_pkg.sv
package csr_chk_pkg;
  localparam int ADDR_W  = 12;
  localparam int EXT_W   = 2;
  localparam int EXT_FLT = 0;  // counter privilege-filter extension
  localparam int EXT_OVF = 1;  // counter overflow extension

  typedef enum logic [1:0] {
    VMODE_DIRECT   = 2'd0,
    VMODE_VECTORED = 2'd1,
    VMODE_RSV2     = 2'd2,
    VMODE_RSV3     = 2'd3
  } vec_mode_e;
endpackage

// File: rtl/csr_ro_rule.sv
module csr_ro_rule
  import csr_chk_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic          is_write_i,
  output logic          ro_fault_o
);
  localparam int TOP = AW - 1;

  logic ro_space;

  always_comb begin
    ro_space   = (addr_i[TOP -: 2] == 2'b11);
    ro_fault_o = is_write_i && ro_space;
  end
endmodule

// File: rtl/csr_ext_gate.sv
module csr_ext_gate
  import csr_chk_pkg::*;
#(
  parameter int          AW         = ADDR_W,
  parameter logic [11:0] CYC_CFG    = 12'h321,
  parameter logic [11:0] INS_CFG    = 12'h322,
  parameter logic [11:0] CYC_CFGH   = 12'h721,
  parameter logic [11:0] INS_CFGH   = 12'h722,
  parameter logic [11:0] EVTH_FIRST = 12'h723,
  parameter int          EVT_CNT    = 29
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             mode64_i,
  input  logic [EXT_W-1:0] ext_i,
  output logic             ext_fault_o
);
  logic [EVT_CNT-1:0] evt_match;
  logic cfg_lo_hit, cfg_hi_hit, evt_hi_hit;

  for (genvar g = 0; g < EVT_CNT; g++) begin : g_evth
    localparam logic [AW-1:0] SLOT = AW'(EVTH_FIRST + g);
    assign evt_match[g] = (addr_i == SLOT);
  end

  always_comb begin
    cfg_lo_hit  = (addr_i == AW'(CYC_CFG))  || (addr_i == AW'(INS_CFG));
    cfg_hi_hit  = (addr_i == AW'(CYC_CFGH)) || (addr_i == AW'(INS_CFGH));
    evt_hi_hit  = |evt_match;
    ext_fault_o = ((cfg_lo_hit || cfg_hi_hit) && !ext_i[EXT_FLT])
               || ((cfg_hi_hit || evt_hi_hit) && mode64_i)
               || (evt_hi_hit && !ext_i[EXT_OVF]);
  end

  always_comb begin
    // R4
    upper_cfg_width_chk : assert (!(cfg_hi_hit && mode64_i) || ext_fault_o);
    // R5
    upper_evt_width_chk : assert (!(evt_hi_hit && mode64_i) || ext_fault_o);
  end
endmodule

// File: rtl/csr_tvec_filter.sv
module csr_tvec_filter
  import csr_chk_pkg::*;
#(
  parameter int          AW        = ADDR_W,
  parameter logic [11:0] TVEC_ADDR = 12'h205
) (
  input  logic [AW-1:0] addr_i,
  input  logic          is_write_i,
  input  logic [1:0]    vec_mode_i,
  output logic          wr_candidate_o
);
  vec_mode_e mode;
  logic      mode_ok;
  logic      tvec_hit;

  always_comb begin
    mode           = vec_mode_e'(vec_mode_i);
    mode_ok        = (mode == VMODE_DIRECT) || (mode == VMODE_VECTORED);
    tvec_hit       = (addr_i == AW'(TVEC_ADDR));
    wr_candidate_o = tvec_hit && is_write_i && mode_ok;
  end

  always_comb begin
    // R7
    reserved_mode_drop_chk : assert (!wr_candidate_o || !vec_mode_i[1]);
  end
endmodule

// File: rtl/csr_access_checker.sv
module csr_access_checker
  import csr_chk_pkg::*;
#(
  parameter logic [11:0] TVEC_ADDR  = 12'h205,
  parameter logic [11:0] CYC_CFG    = 12'h321,
  parameter logic [11:0] INS_CFG    = 12'h322,
  parameter logic [11:0] CYC_CFGH   = 12'h721,
  parameter logic [11:0] INS_CFGH   = 12'h722,
  parameter logic [11:0] EVTH_FIRST = 12'h723,
  parameter int          EVT_CNT    = 29
) (
  input  logic [11:0] addr_i,
  input  logic        is_write_i,
  input  logic        mode64_i,
  input  logic [1:0]  ext_i,
  input  logic [1:0]  vec_mode_i,
  output logic        illegal_o,
  output logic        tvec_we_o
);
  logic ro_fault;
  logic ext_fault;
  logic wr_candidate;

  csr_ro_rule #(.AW(ADDR_W)) u_ro (
    .addr_i     (addr_i),
    .is_write_i (is_write_i),
    .ro_fault_o (ro_fault)
  );

  csr_ext_gate #(
    .AW(ADDR_W), .CYC_CFG(CYC_CFG), .INS_CFG(INS_CFG),
    .CYC_CFGH(CYC_CFGH), .INS_CFGH(INS_CFGH),
    .EVTH_FIRST(EVTH_FIRST), .EVT_CNT(EVT_CNT)
  ) u_ext (
    .addr_i      (addr_i),
    .mode64_i    (mode64_i),
    .ext_i       (ext_i),
    .ext_fault_o (ext_fault)
  );

  csr_tvec_filter #(.AW(ADDR_W), .TVEC_ADDR(TVEC_ADDR)) u_tvec (
    .addr_i         (addr_i),
    .is_write_i     (is_write_i),
    .vec_mode_i     (vec_mode_i),
    .wr_candidate_o (wr_candidate)
  );

  always_comb begin
    illegal_o = ro_fault || ext_fault;
    tvec_we_o = wr_candidate && !illegal_o;
  end

  always_comb begin
    // R8
    strobe_needs_legal_chk : assert (!tvec_we_o || !illegal_o);
    // R8
    strobe_needs_write_chk : assert (!tvec_we_o || is_write_i);
    // R2
    read_never_ro_chk : assert (is_write_i || !ro_fault);
  end
endmodule

// File: tb/tb_csr_access_checker.sv
module tb_csr_access_checker;
  logic        clk = 1'b0;
  logic [11:0] addr;
  logic        wr, m64;
  logic [1:0]  ext, vmode;
  logic        illegal, we;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  localparam int N_ADDR = 41;

  csr_access_checker dut (
    .addr_i(addr), .is_write_i(wr), .mode64_i(m64), .ext_i(ext),
    .vec_mode_i(vmode), .illegal_o(illegal), .tvec_we_o(we)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [11:0] addr_at(int i);
    if (i == 0) return 12'h205;
    if (i == 1) return 12'h321;
    if (i == 2) return 12'h322;
    if (i == 3) return 12'h721;
    if (i == 4) return 12'h722;
    if (i < 34) return 12'(12'h723 + (i - 5));
    case (i)
      34: return 12'hC00;
      35: return 12'hC02;
      36: return 12'hC83;
      37: return 12'hFFF;
      38: return 12'h000;
      39: return 12'h7FF;
      default: return 12'hB00;
    endcase
  endfunction

  function automatic string tag_of(logic [11:0] a, logic w);
    if (a >= 12'hC00) return w ? "R1" : "R2";
    if (a == 12'h321 || a == 12'h322) return "R3";
    if (a == 12'h721 || a == 12'h722) return "R4";
    if (a >= 12'h723 && a <= 12'h73F) return "R5";
    if (a == 12'h205) return w ? "R6/R7" : "R8";
    return "R9";
  endfunction

  task automatic check(string tag, logic act_i, logic exp_i, logic act_w, logic exp_w);
    vectors++;
    if (act_i !== exp_i || act_w !== exp_w) begin
      fails++;
      $display("FAIL %s addr=%h wr=%b m64=%b ext=%b vm=%0d: act ill=%b we=%b exp ill=%b we=%b",
               tag, addr, wr, m64, ext, vmode, act_i, act_w, exp_i, exp_w);
    end
  endtask

  initial begin
    addr = 12'h000; wr = 1'b0; m64 = 1'b0; ext = 2'b00; vmode = 2'd0;
    @(negedge clk);
    // R9: idle read of an ordinary address is legal
    check("R9", illegal, 1'b0, we, 1'b0);
    for (int ai = 0; ai < N_ADDR; ai++) begin
      for (int w = 0; w < 2; w++) begin
        for (int md = 0; md < 2; md++) begin
          for (int e = 0; e < 4; e++) begin
            for (int vm = 0; vm < 4; vm++) begin
              logic [11:0] a;
              logic e_ro, e_cfg, e_cfgh, e_evt, e_ill, e_we;
              a = addr_at(ai);
              @(negedge clk);
              addr = a; wr = w[0]; m64 = md[0]; ext = e[1:0]; vmode = vm[1:0];
              #5;
              e_ro   = (w == 1) && (a >= 12'hC00);
              e_cfg  = (a == 12'h321 || a == 12'h322) && (e % 2 == 0);
              e_cfgh = (a == 12'h721 || a == 12'h722) && ((e % 2 == 0) || md == 1);
              e_evt  = (a >= 12'h723 && a <= 12'h73F) && ((e / 2 == 0) || md == 1);
              e_ill  = e_ro | e_cfg | e_cfgh | e_evt;
              e_we   = (a == 12'h205) && (w == 1) && (vm < 2) && !e_ill;
              check(tag_of(a, w[0]), illegal, e_ill, we, e_we);
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule